// File: doc/BRIEF.md
# Two-Level I/O Page Table Walker

This block turns a 32-bit I/O virtual address into a physical frame by fetching two entries from memory. It first reads a page-directory entry, which is picked by the top ten address bits. If that entry points to a second-level table, it then reads the table entry, which is picked by the next ten bits. The walker returns either a refill or a fault. A refill carries the frame number and the combined read, write and nonsecure flags.

Each address space identifier has its own directory base register. The register holds the directory's physical frame number in its low bits and three attribute flags in bits 31 (read), 30 (write) and 29 (nonsecure). These registers are written through a plain configuration port.

Miss requests, memory reads and responses all use valid/ready handshakes.
- A miss request is accepted only while `req_ready` is high, and `req_ready` stays low from acceptance until the response has been taken.
- The memory read request holds its address until `mem_req_ready` is seen.
- The memory read data is always accepted, so it has no ready.
- The response holds every field stable until `rsp_ready` is seen.

Top module: `iova_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: The first memory read is at address (base frame << 12) + 4 × VA[31:22]. The base frame is the low PA_W−12 bits of the ASID's directory base register.
- R3: Some directory entries end the walk after one memory read, with fault code 1. This applies to a directory entry that is zero, or that has bit 28 (next level) clear.
- R4: If the directory entry has bit 28 set, the second read is at (entry low PA_W−12 bits << 12) + 4 × VA[21:12].
- R5: A table entry of zero ends the walk with fault code 2 (unmapped).
- R6: The effective flags are the bitwise AND of the base, directory and table entry bits: 31 read, 30 write, 29 nonsecure. A write miss without effective write, or a read miss without effective read, gives fault code 3.
- R7: A refill has fault code 0. It returns the table entry's low PA_W−12 bits as the frame; bits above the frame field and below 29 are ignored. It also returns the effective flags, the request's ASID and VA[31:12].
- R8: Only one walk is in flight. `req_ready` stays low from the acceptance edge until the response handshake completes.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid and all its fields stay unchanged.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the read request stays valid with an unchanged address.
- R11: The walk uses the base value as it stood before its acceptance edge. A configuration write to the same ASID in the acceptance cycle takes effect only from the next walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a directory base register |
| cfg_asid | input | ASID_W | ASID whose base register is written |
| cfg_base | input | 32 | Base value: flags in 31:29, frame in low bits |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_asid | input | ASID_W | ASID of the miss |
| req_va | input | 32 | Virtual address of the miss |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | PA_W | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid (single beat) |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 2 | 0 refill, 1 directory fault, 2 unmapped, 3 permission |
| rsp_pfn | output | PA_W−12 | Physical frame number (0 on a fault) |
| rsp_rd | output | 1 | Effective read permission |
| rsp_wr | output | 1 | Effective write permission |
| rsp_ns | output | 1 | Effective nonsecure flag |
| rsp_asid | output | ASID_W | ASID of the walked request |
| rsp_vpn | output | 20 | VA[31:12] of the walked request |

## Verification
A configuration write and a request acceptance can land on the same clock edge for the same ASID. The bench provokes this by driving `cfg_we` and `req_valid` in the same cycle. It judges the outcome by the address of the first memory read, which must still come from the old base. A second walk on that ASID must then use the new base. Response back-pressure and memory request stalls can also overlap with a walk still in progress. Both are held over several cycles while the bench watches for field stability and for `req_ready` staying low.

// File: rtl/iowalk_pkg.sv
package iowalk_pkg;
  localparam int ENT_W   = 32;
  localparam int IDX_W   = 10;
  localparam int PG_SH   = 12;
  localparam int B_RD    = 31;
  localparam int B_WR    = 30;
  localparam int B_NS    = 29;
  localparam int B_NEXT  = 28;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_REQ, ST_DIR_WAIT, ST_TBL_REQ, ST_TBL_WAIT, ST_RESP
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_DIR   = 2'd1,
    FLT_UNMAP = 2'd2,
    FLT_PERM  = 2'd3
  } fault_e;
endpackage

// File: rtl/ptw_base_table.sv
module ptw_base_table #(
  parameter int ASID_W = 7,
  parameter int ENT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [ENT_W-1:0]  wr_data,
  input  logic [ASID_W-1:0] rd_asid,
  output logic [ENT_W-1:0]  rd_data
);
  localparam int NUM = 1 << ASID_W;

  logic [NUM-1:0][ENT_W-1:0] base_flat;

  for (genvar gi = 0; gi < NUM; gi++) begin : g_ent
    logic [ENT_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  ent_q <= '0;
      else if (wr_en && (wr_asid == ASID_W'(gi)))  ent_q <= wr_data;
    end
    assign base_flat[gi] = ent_q;
  end

  assign rd_data = base_flat[rd_asid];
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import iowalk_pkg::*;
#(
  parameter int PFN_W = 20
) (
  input  logic [ENT_W-1:0] ent,
  output logic             is_zero,
  output logic             is_next,
  output logic [2:0]       flags,
  output logic [PFN_W-1:0] frame
);
  assign is_zero = (ent == '0);
  assign is_next = ent[B_NEXT];
  assign flags   = {ent[B_RD], ent[B_WR], ent[B_NS]};
  assign frame   = ent[PFN_W-1:0];
endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import iowalk_pkg::*;
#(
  parameter int ASID_W = 7,
  parameter int PA_W   = 32,
  localparam int PFN_W = PA_W - PG_SH,
  localparam int VPN_W = 32 - PG_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [31:0]       req_va,
  input  logic              req_write,
  input  logic [ENT_W-1:0]  base_rd,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic              chk_zero,
  input  logic              chk_next,
  input  logic [2:0]        chk_flags,
  input  logic [PFN_W-1:0]  chk_frame,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_fault,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic              rsp_ns,
  output logic [ASID_W-1:0] rsp_asid,
  output logic [VPN_W-1:0]  rsp_vpn
);
  walk_state_e       state_q;
  logic [31:0]       va_q;
  logic              wr_q;
  logic [ASID_W-1:0] asid_q;
  logic [PFN_W-1:0]  dir_frame_q;
  logic [PFN_W-1:0]  tbl_frame_q;
  logic [2:0]        flags_q;
  logic [1:0]        fault_q;
  logic [PFN_W-1:0]  pfn_q;
  logic [2:0]        out_flags_q;
  logic [2:0]        eff_flags;
  logic              perm_ok;
  logic              accept;

  assign accept    = req_valid && req_ready;
  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);

  assign mem_req_valid = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
  assign mem_req_addr  = (state_q == ST_TBL_REQ)
                       ? {tbl_frame_q, va_q[21:12], 2'b00}
                       : {dir_frame_q, va_q[31:22], 2'b00};

  assign eff_flags = flags_q & chk_flags;
  assign perm_ok   = wr_q ? eff_flags[1] : eff_flags[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      asid_q      <= '0;
      dir_frame_q <= '0;
      tbl_frame_q <= '0;
      flags_q     <= '0;
      fault_q     <= FLT_NONE;
      pfn_q       <= '0;
      out_flags_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          va_q        <= req_va;
          wr_q        <= req_write;
          asid_q      <= req_asid;
          dir_frame_q <= base_rd[PFN_W-1:0];
          flags_q     <= {base_rd[B_RD], base_rd[B_WR], base_rd[B_NS]};
          state_q     <= ST_DIR_REQ;
        end
        ST_DIR_REQ: if (mem_req_ready) state_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (mem_rsp_valid) begin
          if (chk_zero || !chk_next) begin
            fault_q     <= FLT_DIR;
            pfn_q       <= '0;
            out_flags_q <= '0;
            state_q     <= ST_RESP;
          end else begin
            flags_q     <= eff_flags;
            tbl_frame_q <= chk_frame;
            state_q     <= ST_TBL_REQ;
          end
        end
        ST_TBL_REQ: if (mem_req_ready) state_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: if (mem_rsp_valid) begin
          state_q <= ST_RESP;
          if (chk_zero) begin
            fault_q     <= FLT_UNMAP;
            pfn_q       <= '0;
            out_flags_q <= '0;
          end else if (!perm_ok) begin
            fault_q     <= FLT_PERM;
            pfn_q       <= '0;
            out_flags_q <= '0;
          end else begin
            fault_q     <= FLT_NONE;
            pfn_q       <= chk_frame;
            out_flags_q <= eff_flags;
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_fault = fault_q;
  assign rsp_pfn   = pfn_q;
  assign rsp_rd    = out_flags_q[2];
  assign rsp_wr    = out_flags_q[1];
  assign rsp_ns    = out_flags_q[0];
  assign rsp_asid  = asid_q;
  assign rsp_vpn   = va_q[31:12];

  assert_one_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) &&
                                   $stable(rsp_pfn) && $stable(rsp_vpn)));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_dir_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DIR_WAIT && mem_rsp_valid && (chk_zero || !chk_next))
      |=> (rsp_valid && rsp_fault == FLT_DIR));

  assert_write_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_NONE && wr_q) |-> rsp_wr);
endmodule

// File: rtl/iova_walker.sv
module iova_walker
  import iowalk_pkg::*;
#(
  parameter int ASID_W = 7,
  parameter int PA_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ASID_W-1:0]    cfg_asid,
  input  logic [31:0]          cfg_base,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ASID_W-1:0]    req_asid,
  input  logic [31:0]          req_va,
  input  logic                 req_write,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [PA_W-1:0]      mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [31:0]          mem_rsp_data,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [1:0]           rsp_fault,
  output logic [PA_W-13:0]     rsp_pfn,
  output logic                 rsp_rd,
  output logic                 rsp_wr,
  output logic                 rsp_ns,
  output logic [ASID_W-1:0]    rsp_asid,
  output logic [19:0]          rsp_vpn
);
  localparam int PFN_W = PA_W - PG_SH;

  logic [ENT_W-1:0] base_rd;
  logic             chk_zero;
  logic             chk_next;
  logic [2:0]       chk_flags;
  logic [PFN_W-1:0] chk_frame;

  ptw_base_table #(.ASID_W(ASID_W), .ENT_W(ENT_W)) u_base (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_asid(cfg_asid), .wr_data(cfg_base),
    .rd_asid(req_asid), .rd_data(base_rd)
  );

  ptw_entry_check #(.PFN_W(PFN_W)) u_chk (
    .ent(mem_rsp_data), .is_zero(chk_zero), .is_next(chk_next),
    .flags(chk_flags), .frame(chk_frame)
  );

  ptw_walk_ctrl #(.ASID_W(ASID_W), .PA_W(PA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_asid(req_asid),
    .req_va(req_va), .req_write(req_write), .base_rd(base_rd),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .chk_zero(chk_zero), .chk_next(chk_next), .chk_flags(chk_flags),
    .chk_frame(chk_frame),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_pfn(rsp_pfn), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ns(rsp_ns),
    .rsp_asid(rsp_asid), .rsp_vpn(rsp_vpn)
  );
endmodule

// File: tb/tb_iova_walker.sv
module tb_iova_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_asid = '0;
  logic [31:0] cfg_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_asid = '0;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_fault;
  logic [19:0] rsp_pfn;
  logic        rsp_rd, rsp_wr, rsp_ns;
  logic [6:0]  rsp_asid;
  logic [19:0] rsp_vpn;

  always #2 clk = ~clk;

  iova_walker dut (.*);

  int total = 0;
  int bad = 0;

  logic [31:0] mem [logic [31:0]];
  int          nreads = 0;
  logic [31:0] rd_addr [4];
  int          stall_left = 0;
  int          stall_bad = 0;
  bit          stall_seen = 0;
  logic [31:0] stall_addr = '0;
  bit          pend = 0;
  logic [31:0] pend_data = '0;
  bit          busy_seen;
  logic [1:0]  g_fault;
  logic [19:0] g_pfn;
  logic        g_rd, g_wr, g_ns;
  logic [6:0]  g_asid;
  logic [19:0] g_vpn;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    mem_req_ready = 1'b1;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pend_data;
        pend = 0;
      end
      if (mem_req_valid) begin
        if (stall_seen && mem_req_addr != stall_addr) stall_bad++;
        if (stall_left > 0) begin
          mem_req_ready = 1'b0;
          stall_addr = mem_req_addr;
          stall_seen = 1;
          stall_left--;
        end else begin
          mem_req_ready = 1'b1;
          stall_seen = 0;
          if (nreads < 4) rd_addr[nreads] = mem_req_addr;
          nreads++;
          pend = 1;
          pend_data = mem_rd(mem_req_addr);
        end
      end else begin
        mem_req_ready = 1'b1;
      end
    end
  end

  task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_asid = a; cfg_base = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_req(input logic [6:0] a, input logic [31:0] va, input bit w,
                           input bit hold);
    nreads = 0;
    rd_addr[0] = '0; rd_addr[1] = '0;
    @(negedge clk);
    req_valid = 1'b1; req_asid = a; req_va = va; req_write = w;
    rsp_ready = !hold;
  endtask

  task automatic finish_req(input bit hold);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b0;
    busy_seen = !req_ready;
    for (int n = 0; n < 200 && !rsp_valid; n++) @(negedge clk);
    g_fault = rsp_fault; g_pfn = rsp_pfn; g_rd = rsp_rd; g_wr = rsp_wr;
    g_ns = rsp_ns; g_asid = rsp_asid; g_vpn = rsp_vpn;
    if (!hold) @(negedge clk);
  endtask

  task automatic do_walk(input logic [6:0] a, input logic [31:0] va, input bit w);
    start_req(a, va, w, 0);
    finish_req(0);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
  endtask

  task automatic t_refill;
    do_walk(7'd1, 32'h0040_3000, 0);
    chk(rd_addr[0] == 32'h0001_0004, "R2 dir addr", rd_addr[0], 32'h0001_0004);
    chk(rd_addr[1] == 32'h0002_000C, "R4 table addr", rd_addr[1], 32'h0002_000C);
    chk(nreads == 2, "R4 read count", nreads, 2);
    chk(g_fault == 2'd0, "R7 fault code", g_fault, 0);
    chk(g_pfn == 20'h00ABC, "R7 pfn masked", g_pfn, 32'hABC);
    chk({g_rd, g_wr, g_ns} == 3'b111, "R7 flags", {g_rd, g_wr, g_ns}, 3'b111);
    chk(g_asid == 7'd1 && g_vpn == 20'h00403, "R7 asid/vpn", {g_asid, g_vpn},
        {7'd1, 20'h00403});
    chk(busy_seen, "R8 busy during walk", busy_seen, 1);
  endtask

  task automatic t_dir_fault;
    do_walk(7'd1, 32'h0080_0000, 0);
    chk(g_fault == 2'd1, "R3 no-next fault", g_fault, 1);
    chk(nreads == 1, "R3 single read", nreads, 1);
    chk(rd_addr[0] == 32'h0001_0008, "R2 dir addr idx2", rd_addr[0], 32'h0001_0008);
    do_walk(7'd1, 32'h0140_0000, 1);
    chk(g_fault == 2'd1 && nreads == 1, "R3 zero entry", {g_fault, nreads[3:0]}, 6'h11);
  endtask

  task automatic t_unmapped;
    do_walk(7'd1, 32'h0040_7000, 0);
    chk(g_fault == 2'd2, "R5 unmapped", g_fault, 2);
    chk(nreads == 2 && rd_addr[1] == 32'h0002_001C, "R5 table addr", rd_addr[1],
        32'h0002_001C);
  endtask

  task automatic t_perm;
    do_walk(7'd1, 32'h0040_4000, 1);
    chk(g_fault == 2'd3, "R6 write to read-only", g_fault, 3);
    do_walk(7'd1, 32'h0040_4000, 0);
    chk(g_fault == 2'd0 && g_pfn == 20'h55, "R6 read of read-only", g_pfn, 32'h55);
    chk({g_rd, g_wr, g_ns} == 3'b101, "R6 flags read-only", {g_rd, g_wr, g_ns}, 3'b101);
    do_walk(7'd2, 32'h0040_3000, 1);
    chk(g_fault == 2'd3, "R6 base denies write", g_fault, 3);
    do_walk(7'd2, 32'h0040_3000, 0);
    chk(g_fault == 2'd0 && {g_rd, g_wr, g_ns} == 3'b100, "R6 base-limited flags",
        {g_fault, g_rd, g_wr, g_ns}, 5'b00100);
  endtask

  task automatic t_hold;
    logic [19:0] p0;
    start_req(7'd1, 32'h0040_3000, 0, 1);
    finish_req(1);
    p0 = rsp_pfn;
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk(rsp_valid && rsp_pfn == p0 && rsp_fault == 2'd0, "R9 held response",
        rsp_pfn, p0);
    chk(!req_ready, "R8 not ready while held", req_ready, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R8 ready after take", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic t_stall;
    stall_left = 3;
    stall_bad = 0;
    do_walk(7'd1, 32'h0040_3000, 0);
    chk(stall_bad == 0, "R10 addr stable in stall", stall_bad, 0);
    chk(rd_addr[0] == 32'h0001_0004 && g_pfn == 20'h00ABC, "R10 result after stall",
        g_pfn, 32'hABC);
  endtask

  task automatic t_same_cycle;
    cfg_write(7'd3, 32'hE000_0010);
    start_req(7'd3, 32'h0040_3000, 0, 0);
    cfg_we = 1'b1; cfg_asid = 7'd3; cfg_base = 32'hE000_0040;
    finish_req(0);
    chk(rd_addr[0] == 32'h0001_0004, "R11 old base used", rd_addr[0], 32'h0001_0004);
    chk(g_fault == 2'd0, "R11 walk result", g_fault, 0);
    do_walk(7'd3, 32'h0040_3000, 0);
    chk(rd_addr[0] == 32'h0004_0004, "R11 new base next walk", rd_addr[0],
        32'h0004_0004);
    chk(g_fault == 2'd1, "R11 new dir empty", g_fault, 1);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mem[32'h0001_0004] = 32'hF000_0020;
    mem[32'h0001_0008] = 32'hE000_0030;
    mem[32'h0002_000C] = 32'hE100_0ABC;
    mem[32'h0002_0010] = 32'hA000_0055;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    cfg_write(7'd1, 32'hE000_0010);
    cfg_write(7'd2, 32'h8000_0010);
    t_refill();
    t_dir_fault();
    t_unmapped();
    t_perm();
    t_hold();
    t_stall();
    t_same_cycle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule